// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in/first-out buffer of 64 words of 4 bits. It sits on a dual-port storage array with its own write and read pointers. Producers and consumers talk to it with a strobe-and-flag handshake rather than with enables. On the write side, a strobe `shift_in` is paired with a ready flag `in_ready`. On the read side, a strobe `shift_out` is paired with a ready flag `out_ready`. A word is taken when its strobe is high, and its pointer moves when the strobe falls. While a strobe is being serviced, the matching flag stays low.

Both strobes and the active-low master reset come from outside the system clock domain. Each passes through a synchronizer, and the synchronizer that handles the strobes also finds their falling edges. All flag updates happen on `clk`. A word that lands in an empty buffer falls through to the data output with no read strobe, and `out_ready` rises to mark it. When the buffer runs dry, the last word read stays on the output. An active-low drive enable forces the data output to zero and reports whether the output is being driven.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds at most 64 words. With 64 words stored, `in_ready` is low. A `shift_in` pulse that starts and ends while the buffer is full stores nothing, so that word never appears at the output.
- R2: When `shift_in` is high and `in_ready` is high, the word on `wr_data` is stored and `in_ready` goes low. `in_ready` stays low until `shift_in` falls. It then returns high unless the buffer is full.
- R3: If `shift_in` is held high while the buffer is full, the word on `wr_data` is stored as soon as a read frees a slot. `in_ready` is then low again for as long as `shift_in` stays high.
- R4: When `shift_out` is high and `out_ready` is high, `out_ready` goes low. After `shift_out` falls, the next stored word, if there is one, is shown with `out_ready` high. If there is no further word, `out_ready` stays low.
- R5: A `shift_out` pulse that starts and ends while `out_ready` is low consumes nothing. A word written afterwards stays shown with `out_ready` high.
- R6: `rd_data` changes only in the cycle where `out_ready` rises, apart from reset. Words come out in the order they were written.
- R7: Once the buffer is empty, `rd_data` keeps the last word shown and `out_ready` stays low.
- R8: A word written into an empty buffer appears on `rd_data` with `out_ready` high, with no read strobe needed.
- R9: If `shift_out` is held high while the buffer is empty and words are written, the first word raises `out_ready` for exactly one clock cycle and then stays on `rd_data`. Later words are not shown until `shift_out` falls.
- R10: While `mrst_n` is low, `in_ready` is high, `out_ready` is low, `rd_data` is zero and all stored words are discarded.
- R11: If `shift_in` is high when `mrst_n` is released, the word on `wr_data` is stored. `in_ready` stays low until `shift_in` falls, and the word later appears at the output.
- R12: While `drive_n` is high, `rd_data` is zero and `rd_drive` is low. While `drive_n` is low, `rd_data` shows the held word and `rd_drive` is high.
- R13: Writes and reads running at the same time keep every word, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| shift_in | input | 1 | Write strobe (asynchronous level) |
| wr_data | input | DATA_W | Word to store; hold it stable while `shift_in` is high |
| in_ready | output | 1 | High when a write strobe will be accepted |
| shift_out | input | 1 | Read strobe (asynchronous level) |
| rd_data | output | DATA_W | Word on the output, or zero while the output is not driven |
| out_ready | output | 1 | High while `rd_data` holds an unread word |
| drive_n | input | 1 | Output drive enable, active low |
| rd_drive | output | 1 | High while `rd_data` is driven |

## Verification
Suppose the read pointer slips. Then the next rise of `out_ready` shows a word out of order, so the queue-based scoreboard catches it on the very next read. A write pointer that advances at the wrong time either loses a word or repeats one, and this also shows up at the first read that reaches that slot. A hold state that gets stuck shows at once as an `in_ready` or `out_ready` that never comes back, and the bench reports it. A fill count that goes wrong shows up in the full boundary: either the 65th strobe is accepted, or the held write is not stored after one read.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   // synchronized strobe: current level plus a one-cycle falling-edge mark
   typedef struct packed {
      logic lvl;
      logic fall;
   } strobe_t;
endpackage

// File: rtl/sfifo_rst_sync.sv
module sfifo_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfifo_rst_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/sfifo_sync.sv
module sfifo_sync
   import sfifo_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_i,
   input  logic    async_in,
   output strobe_t strobe_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfifo_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst_i) begin
      if (rst_i) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign strobe_o.lvl  = chain[STAGES-1];
   assign strobe_o.fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
   parameter int DATA_W = 4,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
   import sfifo_pkg::*;
#(
   parameter int DATA_W      = 4,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              shift_in,
   input  logic [DATA_W-1:0] wr_data,
   output logic              in_ready,
   input  logic              shift_out,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_ready,
   input  logic              drive_n,
   output logic              rd_drive
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("strobe_fifo DEPTH must be a power of two");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("strobe_fifo DATA_W must be positive");
      end
   endgenerate

   logic              rst_i;
   strobe_t           si_s, so_s;
   logic [PW-1:0]     wptr, rptr, fill;
   logic              wr_hold, rd_hold, out_rdy_q;
   logic [DATA_W-1:0] dout_q, mem_rd;
   logic              full, has_word, load, commit, accept, advance, present;

   sfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk(clk), .arst_n(mrst_n), .rst_o(rst_i));
   sfifo_sync #(.STAGES(SYNC_STAGES)) u_si (
      .clk(clk), .rst_i(rst_i), .async_in(shift_in), .strobe_o(si_s));
   sfifo_sync #(.STAGES(SYNC_STAGES)) u_so (
      .clk(clk), .rst_i(rst_i), .async_in(shift_out), .strobe_o(so_s));

   sfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .we(load), .waddr(wptr[AW-1:0]), .wdata(wr_data),
      .raddr(rptr[AW-1:0]), .rdata(mem_rd));

   // occupancy from pointers carrying a wrap bit
   assign fill     = wptr - rptr;
   assign full     = (fill == PW'(DEPTH));
   assign has_word = (fill != '0);

   // write side: store while strobe high, commit on its falling edge
   assign in_ready = ~wr_hold & ~full;
   assign load     = si_s.lvl & in_ready;
   assign commit   = wr_hold & si_s.fall;

   always_ff @(posedge clk or posedge rst_i) begin
      if (rst_i) begin
         wptr    <= '0;
         wr_hold <= 1'b0;
      end else if (load) begin
         wr_hold <= 1'b1;
      end else if (commit) begin
         wr_hold <= 1'b0;
         wptr    <= wptr + PW'(1);
      end
   end

   // read side: flag drops while strobe high, pointer moves on its fall
   assign accept  = out_rdy_q & so_s.lvl;
   assign advance = rd_hold & so_s.fall;
   assign present = ~out_rdy_q & ~rd_hold & has_word;

   always_ff @(posedge clk or posedge rst_i) begin
      if (rst_i) begin
         rptr      <= '0;
         rd_hold   <= 1'b0;
         out_rdy_q <= 1'b0;
         dout_q    <= '0;
      end else if (accept) begin
         out_rdy_q <= 1'b0;
         rd_hold   <= 1'b1;
      end else if (advance) begin
         rd_hold   <= 1'b0;
         rptr      <= rptr + PW'(1);
      end else if (present) begin
         dout_q    <= mem_rd;
         out_rdy_q <= 1'b1;
      end
   end

   assign out_ready = out_rdy_q;
   assign rd_drive  = ~drive_n;
   assign rd_data   = drive_n ? '0 : dout_q;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
   parameter int DATA_W = 4,
   parameter int DEPTH  = 64,
   localparam int PW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_i,
   input logic              in_ready,
   input logic              out_ready,
   input logic [PW-1:0]     wptr,
   input logic [PW-1:0]     rptr,
   input logic [DATA_W-1:0] dout_q
);
   logic [PW-1:0] occ;
   assign occ = wptr - rptr;

   a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst_i)
      occ <= PW'(DEPTH));

   a_r2_wptr_step: assert property (@(posedge clk) disable iff (rst_i)
      !$stable(wptr) |-> ($past(!in_ready) && wptr == $past(wptr) + PW'(1)));

   a_r4_rptr_step: assert property (@(posedge clk) disable iff (rst_i)
      !$stable(rptr) |-> ($past(!out_ready) && rptr == $past(rptr) + PW'(1)));

   a_r6_data_moves_with_flag: assert property (@(posedge clk) disable iff (rst_i)
      !$stable(dout_q) |-> $rose(out_ready));

   a_r7_empty_not_ready: assert property (@(posedge clk) disable iff (rst_i)
      (occ == '0) |-> !out_ready);

   a_r10_reset_state: assert property (@(posedge clk)
      (rst_i && $past(rst_i)) |-> (in_ready && !out_ready && dout_q == '0));
endmodule

bind strobe_fifo sfifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_i(rst_i), .in_ready(in_ready), .out_ready(out_ready),
   .wptr(wptr), .rptr(rptr), .dout_q(dout_q));

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
   logic       clk = 1'b0;
   logic       mrst_n = 1'b0, shift_in = 1'b0, shift_out = 1'b0, drive_n = 1'b0;
   logic [3:0] wr_data = '0;
   logic [3:0] rd_data;
   logic       in_ready, out_ready, rd_drive;

   int total = 0, bad = 0;
   logic [3:0] q[$];
   logic ordy_prev = 1'b0;
   bit   meas = 1'b0;
   int   hi_cnt = 0;

   always #4 clk = ~clk;

   strobe_fifo dut_i (
      .clk(clk), .mrst_n(mrst_n), .shift_in(shift_in), .wr_data(wr_data),
      .in_ready(in_ready), .shift_out(shift_out), .rd_data(rd_data),
      .out_ready(out_ready), .drive_n(drive_n), .rd_drive(rd_drive));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: every rise of out_ready must show the oldest expected word
   always @(negedge clk) begin
      if (out_ready && !ordy_prev) begin
         if (q.size() == 0) chk("R6 unexpected word", int'(rd_data), -1);
         else chk("R6 order", int'(rd_data), int'(q.pop_front()));
      end
      ordy_prev <= out_ready;
      if (meas && out_ready) hi_cnt++;
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic push_word(input logic [3:0] v);
      while (!in_ready) @(negedge clk);
      tick(1);
      wr_data  = v;
      shift_in = 1'b1;
      q.push_back(v);
      while (in_ready) @(negedge clk);
      tick(1);
      shift_in = 1'b0;
   endtask

   task automatic pop_word(input int hold);
      while (!out_ready) @(negedge clk);
      tick(1);
      shift_out = 1'b1;
      tick(hold);
      while (out_ready) @(negedge clk);
      tick(1);
      shift_out = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      settle(5);
      chk("R10 in_ready in reset", int'(in_ready), 1);
      chk("R10 out_ready in reset", int'(out_ready), 0);
      chk("R10 rd_data in reset", int'(rd_data), 0);
      tick(1); mrst_n = 1'b1;
      tick(4);

      // R5: read strobe on empty buffer consumes nothing
      shift_out = 1'b1; tick(6); shift_out = 1'b0; tick(6);
      push_word(4'h5);
      settle(20);
      chk("R8 fall-through flag", int'(out_ready), 1);
      chk("R5 word kept shown", int'(rd_data), 5);
      pop_word(1);
      settle(10);
      chk("R7 flag low when empty", int'(out_ready), 0);
      chk("R7 last word held", int'(rd_data), 5);

      // R4: ordinary traffic
      push_word(4'h1); push_word(4'h2); push_word(4'h3);
      for (int i = 0; i < 3; i++) pop_word(2);
      settle(10);
      chk("R4 no further word", int'(out_ready), 0);

      // R1: fill to full
      for (int i = 0; i < 64; i++) push_word(4'((i * 5 + 2) % 16));
      settle(10);
      chk("R1 in_ready low when full", int'(in_ready), 0);
      tick(1); wr_data = 4'hF; shift_in = 1'b1; tick(8); shift_in = 1'b0; tick(8);
      chk("R1 still full after ignored strobe", int'(in_ready), 0);
      // R3: held write completes once a slot frees
      wr_data = 4'hA; shift_in = 1'b1; q.push_back(4'hA);
      settle(6);
      chk("R3 waits while full", int'(in_ready), 0);
      pop_word(1);
      settle(10);
      chk("R3 in_ready low while strobe held", int'(in_ready), 0);
      tick(1); shift_in = 1'b0;
      settle(8);
      chk("R1 full again after held write", int'(in_ready), 0);
      for (int i = 0; i < 64; i++) pop_word(1);
      settle(12);
      chk("R1 drained empty", int'(out_ready), 0);
      chk("R1 ignored word absent", q.size(), 0);
      chk("R2 in_ready back high", int'(in_ready), 1);

      // R9: read strobe held high while words arrive
      tick(1); shift_out = 1'b1; meas = 1'b1;
      push_word(4'h3);
      push_word(4'h7);
      settle(15);
      meas = 1'b0;
      chk("R9 single-cycle pulse", hi_cnt, 1);
      chk("R9 flag low after pulse", int'(out_ready), 0);
      chk("R9 first word stays", int'(rd_data), 3);
      tick(1); shift_out = 1'b0;
      while (!out_ready) @(negedge clk);
      chk("R9 next word after release", int'(rd_data), 7);

      // R12: output drive enable
      tick(1); drive_n = 1'b1; settle(2);
      chk("R12 data zero when not driven", int'(rd_data), 0);
      chk("R12 drive flag low", int'(rd_drive), 0);
      tick(1); drive_n = 1'b0; settle(2);
      chk("R12 data back when driven", int'(rd_data), 7);
      chk("R12 drive flag high", int'(rd_drive), 1);
      pop_word(1);

      // R13: concurrent writer and reader
      fork
         for (int i = 0; i < 40; i++) push_word(4'((i * 7) % 16));
         for (int i = 0; i < 40; i++) pop_word(1 + (i % 4));
      join
      settle(12);
      chk("R13 all words delivered", q.size(), 0);

      // R10/R11: reset with write strobe high
      push_word(4'h9); push_word(4'h6);
      settle(12);
      tick(1); mrst_n = 1'b0; shift_in = 1'b1; wr_data = 4'hC;
      settle(3);
      chk("R10 in_ready during reset", int'(in_ready), 1);
      chk("R10 out_ready during reset", int'(out_ready), 0);
      chk("R10 rd_data cleared", int'(rd_data), 0);
      q.delete();
      q.push_back(4'hC);
      tick(1); mrst_n = 1'b1;
      settle(10);
      chk("R11 in_ready low while strobe held", int'(in_ready), 0);
      tick(1); shift_in = 1'b0;
      while (!out_ready) @(negedge clk);
      chk("R11 word stored at release", int'(rd_data), 12);
      pop_word(1);
      settle(10);
      chk("R11 nothing else stored", int'(out_ready), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule